// File: doc/BRIEF.md
# Bus initiator transaction tracker

This block runs the initiator side of a parallel PCI-style bus for one local client. The local side asks for a transaction by raising a start strobe. The block then requests the bus and waits for the grant. It gives the local side a one-cycle address acknowledge, and in that cycle the local side drives the address, the command and the beat count without a register in between. The block then puts the address phase on the bus and runs the data phases until the count is used up or the target ends the transfer.

The local ready input is registered straight into the bus IRDY#, so it is sampled one clock before the beat it governs. It is the only way the initiator adds wait states. The block has a local acknowledge that follows the target's TRDY# during data phases, and a pulse that marks each beat that completed. A 10-bit status word tracks the bus phase and the cause of termination: latency timer expiry, retry, disconnect with data, or disconnect without data. It also carries a one-cycle-delayed beat flag and the target's 64-bit acknowledge.

Top module: `pci_init_tracker`

## Requirements
- R1: While rst is high and in the first cycle after it falls, req_n, frame_n, irdy_n, l_adr_ack_n, l_ack_n and l_xfr_n are 1 and l_status is 0.
- R2: A start in idle gives req_n=0 and l_status[0]=1 one cycle later. After gnt_n=0 is sampled, l_adr_ack_n is 0 for exactly one cycle, and l_addr/l_cmd from that cycle appear on bus_ad/bus_cbe with frame_n=0 and l_status[2]=1 in the next cycle.
- R3: l_status[1] (grant seen) is 1 in the acknowledge, address and data cycles and 0 while requesting. l_status[3] is 1 from the first data cycle up to the turnaround cycle. Bits 0, 2 and 3 are never high together.
- R4: In a data cycle, irdy_n equals l_rdy_n of the previous cycle, except that an asserted irdy_n stays asserted until a beat completes. irdy_n is 0 in the first data cycle if l_rdy_n was 0 during the address phase, and it is 1 outside data cycles.
- R5: l_ack_n is 0 exactly in data cycles in which trdy_n is 0.
- R6: A beat completes in a data cycle with irdy_n, trdy_n and devsel_n all 0. In the following cycle l_status[8]=1 and l_xfr_n=0. frame_n is 1 in a data cycle when one beat remains or the latency flag is set. Without a stop, the transaction ends after l_len beats (a zero count is taken as 1) with a clear cause field.
- R7: stop_n=0 with no beat completing and no earlier beat ends the transaction with l_status[7:4]=4'b0010 (retry).
- R8: stop_n=0 in a cycle in which a beat completes ends with l_status[7:4]=4'b1000 (disconnect with data).
- R9: stop_n=0 with no beat completing, after at least one beat, ends with l_status[7:4]=4'b0100 (disconnect without data).
- R10: The latency counter loads lat_cfg in the address phase and counts down by one each data cycle. A data cycle with the counter at 0 and gnt_n=1 sets a flag. The next completed beat then ends the transaction with l_status[7:4]=4'b0001. While gnt_n stays 0 the counter has no effect.
- R11: The cause field has at most one bit set. It holds from the end of a transaction until the next start, and it reads 0 in the request cycle.
- R12: With BUS64=1, l_status[9] is 1 from the data cycle after ack64_n=0 is seen with devsel_n=0 until the next acknowledge. With BUS64=0 it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_start | input | 1 | Local request for a new transaction |
| l_len | input | LEN_W | Beat count, taken while l_adr_ack_n is 0 |
| l_addr | input | ADDR_W | Transaction address, taken while l_adr_ack_n is 0 |
| l_cmd | input | 4 | Bus command, taken while l_adr_ack_n is 0 |
| l_rdy_n | input | 1 | Local ready, active low, sampled one clock ahead of the beat |
| lat_cfg | input | LAT_W | Latency timer reload value |
| l_adr_ack_n | output | 1 | Address acknowledge, active low, one cycle |
| l_ack_n | output | 1 | Local acknowledge, active low, follows target ready in data cycles |
| l_xfr_n | output | 1 | Beat-completed pulse, active low |
| l_status | output | 10 | Phase, cause, beat and 64-bit status |
| req_n | output | 1 | Bus request |
| gnt_n | input | 1 | Bus grant |
| frame_n | output | 1 | Bus FRAME# |
| irdy_n | output | 1 | Bus IRDY# |
| trdy_n | input | 1 | Target ready |
| stop_n | input | 1 | Target stop |
| devsel_n | input | 1 | Target claim |
| ack64_n | input | 1 | Target 64-bit acknowledge |
| bus_ad | output | ADDR_W | Address driven in the address phase |
| bus_cbe | output | 4 | Command driven in the address phase |

## Verification
The bench builds the block with BUS64=1, so the 64-bit acknowledge path and status bit 9 can be observed. It uses LEN_W=4, which allows bursts long enough to outlast small latency loads, and LAT_W=8, which lets a load of 2 expire after three data cycles. Bursts of up to eight beats with random target and local wait patterns run alongside directed retry, both disconnect kinds, and latency expiry with the grant removed and with it held.

// File: rtl/pci_trk_pkg.sv
package pci_trk_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_ACK  = 3'd2,
    S_ADDR = 3'd3,
    S_DATA = 3'd4,
    S_TURN = 3'd5
  } trk_state_e;

  // cause vector bit positions (status bits 4..7)
  localparam int C_LAT  = 0;
  localparam int C_RTRY = 1;
  localparam int C_DWOD = 2;
  localparam int C_DWD  = 3;
endpackage

// File: rtl/pci_trk_lat.sv
module pci_trk_lat #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [LAT_W-1:0] init,
  output logic             expired
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= init;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - LAT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pci_trk_beats.sv
module pci_trk_beats #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec,
  output logic             last_beat,
  output logic             any_beat
);
  logic [LEN_W-1:0] rem_q;
  logic             any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      any_q <= 1'b0;
    end else if (load) begin
      rem_q <= (len == '0) ? LEN_W'(1) : len;
      any_q <= 1'b0;
    end else if (dec) begin
      rem_q <= rem_q - LEN_W'(1);
      any_q <= 1'b1;
    end
  end

  assign last_beat = (rem_q == LEN_W'(1));
  assign any_beat  = any_q;
endmodule

// File: rtl/pci_trk_term.sv
module pci_trk_term import pci_trk_pkg::*; (
  input  logic       in_data,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  input  logic       devsel_n,
  input  logic       any_beat,
  input  logic       lat_flag,
  input  logic       last_beat,
  output logic       xfer,
  output logic       finish,
  output logic [3:0] cause
);
  logic stop_hit;

  assign xfer     = in_data && !devsel_n && !irdy_n && !trdy_n;
  assign stop_hit = in_data && !devsel_n && !stop_n;
  assign finish   = stop_hit || (xfer && (last_beat || lat_flag));

  always_comb begin
    cause = '0;
    if (stop_hit) begin
      if (xfer)          cause[C_DWD]  = 1'b1;
      else if (any_beat) cause[C_DWOD] = 1'b1;
      else               cause[C_RTRY] = 1'b1;
    end else if (xfer && lat_flag && !last_beat) begin
      cause[C_LAT] = 1'b1;
    end
  end
endmodule

// File: rtl/pci_init_tracker.sv
module pci_init_tracker import pci_trk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int LAT_W  = 8,
  parameter bit BUS64  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_start,
  input  logic [LEN_W-1:0]  l_len,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [3:0]        l_cmd,
  input  logic              l_rdy_n,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic              l_adr_ack_n,
  output logic              l_ack_n,
  output logic              l_xfr_n,
  output logic [9:0]        l_status,
  output logic              req_n,
  input  logic              gnt_n,
  output logic              frame_n,
  output logic              irdy_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic              devsel_n,
  input  logic              ack64_n,
  output logic [ADDR_W-1:0] bus_ad,
  output logic [3:0]        bus_cbe
);
  trk_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;
  logic              irdy_q, irdy_d;
  logic              dph_q, t64_q, latf_q;
  logic [3:0]        cause_q, cause_d;
  logic              in_data, xfer, finish, last_beat, any_beat, lat_exp;

  assign in_data = (state_q == S_DATA);

  pci_trk_term u_term (
    .in_data   (in_data),
    .irdy_n    (irdy_q),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .devsel_n  (devsel_n),
    .any_beat  (any_beat),
    .lat_flag  (latf_q),
    .last_beat (last_beat),
    .xfer      (xfer),
    .finish    (finish),
    .cause     (cause_d)
  );

  pci_trk_beats #(.LEN_W(LEN_W)) u_beats (
    .clk       (clk),
    .rst       (rst),
    .load      (state_q == S_ACK),
    .len       (l_len),
    .dec       (xfer),
    .last_beat (last_beat),
    .any_beat  (any_beat)
  );

  pci_trk_lat #(.LAT_W(LAT_W)) u_lat (
    .clk     (clk),
    .rst     (rst),
    .load    (state_q == S_ADDR),
    .run     (in_data),
    .init    (lat_cfg),
    .expired (lat_exp)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (l_start) state_d = S_REQ;
      S_REQ:   if (!gnt_n)  state_d = S_ACK;
      S_ACK:   state_d = S_ADDR;
      S_ADDR:  state_d = S_DATA;
      S_DATA:  if (finish)  state_d = S_TURN;
      S_TURN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // initiator ready: local ready one clock ahead, held while a beat waits
  always_comb begin
    if (state_d != S_DATA)              irdy_d = 1'b1;
    else if (in_data && !irdy_q && !xfer) irdy_d = 1'b0;
    else                                irdy_d = l_rdy_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
      irdy_q  <= 1'b1;
      dph_q   <= 1'b0;
      latf_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      irdy_q  <= irdy_d;
      dph_q   <= xfer;
      if (state_q == S_ACK) begin
        addr_q <= l_addr;
        cmd_q  <= l_cmd;
      end
      if (state_q == S_IDLE && l_start) cause_q <= '0;
      else if (in_data && finish)       cause_q <= cause_d;
      if (state_q == S_ADDR)                    latf_q <= 1'b0;
      else if (in_data && lat_exp && gnt_n)     latf_q <= 1'b1;
    end
  end

  generate
    if (BUS64) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst || state_q == S_ACK)              t64_q <= 1'b0;
        else if (in_data && !devsel_n && !ack64_n) t64_q <= 1'b1;
      end
    end else begin : g_narrow
      logic unused_ack64;
      assign unused_ack64 = ack64_n;
      assign t64_q = 1'b0;
    end
  endgenerate

  assign req_n       = (state_q != S_REQ);
  assign frame_n     = !((state_q == S_ADDR) || (in_data && !(last_beat || latf_q)));
  assign irdy_n      = irdy_q;
  assign bus_ad      = addr_q;
  assign bus_cbe     = cmd_q;
  assign l_adr_ack_n = (state_q != S_ACK);
  assign l_ack_n     = !(in_data && !trdy_n);
  assign l_xfr_n     = !dph_q;
  assign l_status    = {t64_q, dph_q, cause_q, in_data, (state_q == S_ADDR),
                        (state_q == S_ACK || state_q == S_ADDR || in_data),
                        (state_q == S_REQ)};
endmodule

// File: rtl/pci_init_tracker_chk.sv
module pci_init_tracker_chk #(
  parameter bit BUS64 = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       l_adr_ack_n,
  input logic       l_xfr_n,
  input logic [9:0] l_status,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       devsel_n
);
  AST_ACK_THEN_ADDR: assert property (@(posedge clk) disable iff (rst)
    !l_adr_ack_n |=> (l_adr_ack_n && !frame_n && l_status[2])); // R2

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l_status[3], l_status[2], l_status[0]})); // R3

  AST_IRDY_HELD: assert property (@(posedge clk) disable iff (rst)
    (l_status[3] && !irdy_n && trdy_n && stop_n) |=> !irdy_n); // R4

  AST_IRDY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !l_status[3] |-> irdy_n); // R4

  AST_BEAT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (l_status[3] && !irdy_n && !trdy_n && !devsel_n) |=> (l_status[8] && !l_xfr_n)); // R6

  AST_RETRY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $rose(l_status[5]) |-> l_xfr_n); // R7

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(l_status[7:4])); // R11

  generate
    if (!BUS64) begin : g_narrow_chk
      AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        !l_status[9]); // R12
    end
  endgenerate
endmodule

bind pci_init_tracker pci_init_tracker_chk #(.BUS64(BUS64)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .l_adr_ack_n (l_adr_ack_n),
  .l_xfr_n     (l_xfr_n),
  .l_status    (l_status),
  .frame_n     (frame_n),
  .irdy_n      (irdy_n),
  .trdy_n      (trdy_n),
  .stop_n      (stop_n),
  .devsel_n    (devsel_n)
);

// File: tb/pci_init_tracker_test.sv
`timescale 1ns/1ps
module pci_init_tracker_test;
  localparam int ADDR_W = 32, LEN_W = 4, LAT_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic l_start = 0, l_rdy_n = 0, gnt_n = 0, trdy_n = 1, stop_n = 1, devsel_n = 0, ack64_n = 1;
  logic [LEN_W-1:0] l_len = '0;
  logic [ADDR_W-1:0] l_addr = '0;
  logic [3:0] l_cmd = '0;
  logic [LAT_W-1:0] lat_cfg = '0;
  logic l_adr_ack_n, l_ack_n, l_xfr_n, req_n, frame_n, irdy_n;
  logic [9:0] l_status;
  logic [ADDR_W-1:0] bus_ad;
  logic [3:0] bus_cbe;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  pci_init_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_W(LAT_W), .BUS64(1'b1)) uut (
    .clk(clk), .rst(rst), .l_start(l_start), .l_len(l_len), .l_addr(l_addr), .l_cmd(l_cmd),
    .l_rdy_n(l_rdy_n), .lat_cfg(lat_cfg), .l_adr_ack_n(l_adr_ack_n), .l_ack_n(l_ack_n),
    .l_xfr_n(l_xfr_n), .l_status(l_status), .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .ack64_n(ack64_n),
    .bus_ad(bus_ad), .bus_cbe(bus_cbe));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one transaction; masks index data cycles 0..7, later cycles: target ready, local ready
  task automatic run_txn(input int len, input int lat, input logic [7:0] tm, input logic [7:0] sm,
                         input logic [7:0] lm, input logic [7:0] gm, input logic a64,
                         input int exp_pulses, input logic [3:0] exp_cause);
    int d = 0, pulses = 0, beats = 0, lt = lat, rem = len;
    logic prev_irdy = 1, prev_xfer = 0, prev_lrdy = 0, flagb = 0, seen = 0, fin = 0;
    logic [ADDR_W-1:0] ea = '0;
    logic [3:0] ec = '0;
    @(negedge clk);
    l_start = 1; l_len = LEN_W'(len); lat_cfg = LAT_W'(lat); gnt_n = 0;
    @(negedge clk);
    l_start = 0;
    chk(!req_n && l_status[0] && !l_status[1], "R2 request", {req_n, l_status[1:0]}, 3'b001);
    chk(l_status[7:4] == 4'b0, "R11 cause cleared", l_status[7:4], 0);
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      if (!l_xfr_n) pulses++;
      if (!l_adr_ack_n) begin
        ea = $urandom; ec = 4'($urandom);
        l_addr = ea; l_cmd = ec;
        chk(l_status[1] && !l_status[0], "R3 grant bit", l_status[1:0], 2'b10);
      end else if (l_status[2]) begin
        chk(bus_ad == ea && bus_cbe == ec && !frame_n, "R2 address phase",
            {bus_ad, bus_cbe, frame_n}, {ea, ec, 1'b0});
      end else if (l_status[3]) begin
        logic ei = (d == 0) ? 1'b0 : ((!prev_irdy && !prev_xfer) ? 1'b0 : prev_lrdy);
        chk(irdy_n == ei, "R4 irdy", irdy_n, ei);
        chk(frame_n == (rem == 1 || flagb), "R6 R10 frame", frame_n, (rem == 1 || flagb));
        chk(l_status[1], "R3 grant in data", l_status[1], 1);
        trdy_n   = (d < 8) ? !tm[d] : 1'b0;
        stop_n   = (d < 8) ? !sm[d] : 1'b1;
        gnt_n    = (d < 8) ? gm[d] : gm[7];
        l_rdy_n  = (d < 8) ? lm[d] : 1'b0;
        ack64_n  = !a64;
        #1;
        chk(l_ack_n == trdy_n, "R5 local ack", l_ack_n, trdy_n);
        prev_xfer = !irdy_n && !trdy_n;
        prev_irdy = irdy_n; prev_lrdy = l_rdy_n;
        if (prev_xfer) begin beats++; rem--; end
        if (lt == 0 && gnt_n) flagb = 1; else if (lt > 0) lt--;
        d++; seen = 1;
      end else if (seen) begin
        fin = 1;
        chk(pulses == beats && pulses == exp_pulses, "R6 beat count", pulses, exp_pulses);
        chk(l_status[7:4] == exp_cause, "R7 R8 R9 R10 cause", l_status[7:4], exp_cause);
        chk(l_status[9] == a64, "R12 wide ack", l_status[9], a64);
        chk(irdy_n && l_status[3:0] == 0, "R3 turnaround", {irdy_n, l_status[3:0]}, 5'b10000);
      end
      if (!fin) @(negedge clk);
    end
    if (!fin) chk(0, "R6 transaction hung", 0, 1);
    trdy_n = 1; stop_n = 1; l_rdy_n = 0; gnt_n = 0; ack64_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(l_status[7:4] == exp_cause && l_status[3:0] == 0, "R11 cause held", l_status[7:4], exp_cause);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({req_n, frame_n, irdy_n, l_adr_ack_n, l_ack_n, l_xfr_n} == 6'h3F && l_status == 0,
        "R1 in reset", {req_n, frame_n, irdy_n, l_adr_ack_n, l_ack_n, l_xfr_n, l_status}, 16'hFC00);
    rst = 0;
    @(negedge clk);
    chk({req_n, frame_n, irdy_n, l_adr_ack_n, l_ack_n, l_xfr_n} == 6'h3F && l_status == 0,
        "R1 after reset", {req_n, frame_n, irdy_n, l_adr_ack_n, l_ack_n, l_xfr_n, l_status}, 16'hFC00);
    // R6 plain burst, single beat
    run_txn(3, 255, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 3, 4'b0000);
    run_txn(1, 255, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1, 4'b0000);
    // R7 retry
    run_txn(4, 255, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 0, 4'b0010);
    // R8 disconnect with data
    run_txn(4, 255, 8'hFF, 8'h01, 8'h00, 8'h00, 1'b0, 1, 4'b1000);
    // R9 disconnect without data
    run_txn(4, 255, 8'h01, 8'h02, 8'h00, 8'h00, 1'b0, 1, 4'b0100);
    // R10 latency expiry with grant removed, then with grant held
    run_txn(8, 2, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 4, 4'b0001);
    run_txn(5, 1, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 5, 4'b0000);
    // R4 local wait states, R12 64-bit target
    run_txn(4, 255, 8'hFF, 8'h00, 8'h05, 8'h00, 1'b1, 4, 4'b0000);
    for (int i = 0; i < 24; i++) begin
      int ln = 1 + int'($urandom_range(7));
      run_txn(ln, 255, 8'($urandom), 8'h00, 8'($urandom), 8'h00, 1'($urandom), ln, 4'b0000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule